// File: doc/BRIEF.md
# Dual-Channel ATA Task-File Register Block

This block holds the byte-wide command-block and control-block registers of two legacy ATA channels and serves them over a simple I/O-port bus. The bus has a 16-bit port address, separate read and write strobes, an access-width field and byte-wide data in each direction. Each access is decoded into a channel and a register. Writes update that channel's registers. Reads return a registered byte one cycle after the strobe.

Each channel has two drive slots. A presence input says which slots hold a drive. When the drive picked by a channel's drive-select bit is absent, reads of that channel return fixed placeholder values. A write to the command register raises a one-cycle pulse that carries the channel number and the command byte, so a downstream engine can start execution. Setting the soft-reset bit in the device control register returns that channel's task file to its power-up contents.

Top module: `ata_taskfile_regs`

## Requirements
- R1: A port is routed to channel 0 when (addr & 0xFFF8) = 0x1F0 or (addr & 0xFFFE) = 0x3F6, and to channel 1 when the same masks give 0x170 or 0x376. A write to one channel never changes the other. The low three address bits pick the task-file register: 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high.
- R2: After reset, each channel reads error 0x01, sector count 0x01, sector number 0x01, cylinders 0x00, drive/head 0x00 and status 0x00. Its control output shows 0x08, its features output shows 0x00, and both its drive-select and LBA outputs are 0.
- R3: Offset 1 is split by direction. A write loads the features byte, which appears on `feat_q` (bits 8c+7:8c for channel c). A read returns the error register.
- R4: Offset 7 is split by direction. A write raises `cmd_valid` for exactly one cycle after the write edge, with `cmd_chan` set to the channel and `cmd_code` set to the byte written. A read of offset 7, or of the control port (base+0x206), returns the status register.
- R5: Every write to drive/head (offset 6) stores the written value ORed with 0xA0.
- R6: A read of 0x3F7 or 0x377 returns 0xFF, whether or not a drive is present.
- R7: `drv_present` bit 2c+d marks drive d of channel c as present. When the selected drive is absent, a read of drive/head returns 0xA0 and a read of any other task-file register returns 0x00. Writes still take effect.
- R8: An access with `acc_bytes` other than 1 pulses `acc_err`, produces no read data and no command pulse, and leaves all registers unchanged.
- R9: `drv_sel[c]` shows drive/head bit 4 of channel c, and `lba_mode[c]` shows bit 6.
- R10: A control write (base+0x206) with bit 2 set is kept in full on `devctl_q`. On the next clock, all other registers of that channel, including features, go back to their R2 values. The other channel is left alone.
- R11: A read or write of an undecoded port, of data offset 0, or a write to 0x3F7 or 0x377 pulses `acc_err` and has no other effect.
- R12: Every legal read gives exactly one `rd_valid` pulse, with `rd_data`, in the cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_addr | input | 16 | I/O port address |
| acc_bytes | input | 3 | Access width in bytes; only 1 is legal |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| drv_present | input | 4 | Drive presence, bit 2*channel+drive |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid pulse |
| acc_err | output | 1 | Illegal-access pulse |
| cmd_valid | output | 1 | Command-written pulse |
| cmd_chan | output | 1 | Channel of the command pulse |
| cmd_code | output | 8 | Command byte of that channel |
| drv_sel | output | 2 | Drive-select bit per channel |
| lba_mode | output | 2 | LBA-mode bit per channel |
| feat_q | output | 16 | Features byte per channel |
| devctl_q | output | 16 | Device control byte per channel |

## Verification
The hardest situation to reach is an absent selected drive on one channel while the other channel is intact. The stimulus sets drive/head bit 4 by a write, then clears that slot's presence bit. It then checks that task-file reads collapse to 0x00 or 0xA0, that the unused port still reads 0xFF, and that the neighbouring channel is unaffected. It then selects the present drive again to show that the stored values survived. Soft reset is just as indirect, since its effect lands one clock after the control write. The bench therefore idles through that cycle and then reads back every register it had changed on both channels.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  typedef enum logic [3:0] {
    RS_DATA     = 4'd0,
    RS_FEAT_ERR = 4'd1,
    RS_SCNT     = 4'd2,
    RS_SNUM     = 4'd3,
    RS_CYLL     = 4'd4,
    RS_CYLH     = 4'd5,
    RS_DRVHD    = 4'd6,
    RS_CMD_STAT = 4'd7,
    RS_DEVCTL   = 4'd8,
    RS_ALTADDR  = 4'd9,
    RS_NONE     = 4'd15
  } tf_sel_e;

  typedef struct packed {
    logic [7:0] err;
    logic [7:0] scnt;
    logic [7:0] snum;
    logic [7:0] cyll;
    logic [7:0] cylh;
    logic [7:0] drvhd;
    logic [7:0] stat;
    logic [7:0] cmd;
    logic [7:0] feat;
    logic [7:0] devctl;
  } tf_regs_t;

  localparam logic [7:0] ERR_RST    = 8'h01;
  localparam logic [7:0] SCNT_RST   = 8'h01;
  localparam logic [7:0] SNUM_RST   = 8'h01;
  localparam logic [7:0] DEVCTL_RST = 8'h08;
  localparam logic [7:0] DRVHD_SET  = 8'hA0;
  localparam logic [7:0] UNUSED_RD  = 8'hFF;
  localparam int SRST_BIT   = 2;
  localparam int DRVSEL_BIT = 4;
  localparam int LBA_BIT    = 6;

  localparam tf_regs_t TF_RESET = '{
    err: ERR_RST, scnt: SCNT_RST, snum: SNUM_RST, cyll: 8'h00, cylh: 8'h00,
    drvhd: 8'h00, stat: 8'h00, cmd: 8'h00, feat: 8'h00, devctl: DEVCTL_RST
  };

endpackage

// File: rtl/ata_port_decode.sv
module ata_port_decode
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CH0_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] CH1_BASE = 16'h0170,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 16'h0206
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              chan,
  output tf_sel_e           sel
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] BLK_MASK  = ~ADDR_W'(7);
  localparam logic [ADDR_W-1:0] CTRL_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BASES [NCH] = '{CH0_BASE, CH1_BASE};

  always_comb begin
    hit  = 1'b0;
    chan = 1'b0;
    sel  = RS_NONE;
    for (int c = 0; c < NCH; c++) begin
      if ((addr & BLK_MASK) == BASES[c]) begin
        hit  = 1'b1;
        chan = 1'(c);
        sel  = tf_sel_e'({1'b0, addr[2:0]});
      end else if ((addr & CTRL_MASK) == (BASES[c] + CTRL_OFS)) begin
        hit  = 1'b1;
        chan = 1'(c);
        sel  = addr[0] ? RS_ALTADDR : RS_DEVCTL;
      end
    end
  end
endmodule

// File: rtl/ata_chan_regs.sv
module ata_chan_regs
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  tf_sel_e           sel,
  input  logic [DATA_W-1:0] wr_data,
  output tf_regs_t          q
);
  logic srst_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      srst_pend <= 1'b0;
    end else begin
      srst_pend <= wr_en && (sel == RS_DEVCTL) && wr_data[SRST_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= TF_RESET;
    end else if (srst_pend) begin
      q        <= TF_RESET;
      q.devctl <= q.devctl;
    end else if (wr_en) begin
      case (sel)
        RS_FEAT_ERR: q.feat   <= wr_data;
        RS_SCNT:     q.scnt   <= wr_data;
        RS_SNUM:     q.snum   <= wr_data;
        RS_CYLL:     q.cyll   <= wr_data;
        RS_CYLH:     q.cylh   <= wr_data;
        RS_DRVHD:    q.drvhd  <= wr_data | DRVHD_SET;
        RS_CMD_STAT: q.cmd    <= wr_data;
        RS_DEVCTL:   q.devctl <= wr_data;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/ata_read_mux.sv
module ata_read_mux
  import ata_tf_pkg::*;
(
  input  tf_sel_e    sel,
  input  logic       present,
  input  logic [7:0] err,
  input  logic [7:0] scnt,
  input  logic [7:0] snum,
  input  logic [7:0] cyll,
  input  logic [7:0] cylh,
  input  logic [7:0] drvhd,
  input  logic [7:0] stat,
  output logic [7:0] data
);
  always_comb begin
    data = 8'h00;
    if (sel == RS_ALTADDR) begin
      data = UNUSED_RD;
    end else if (!present) begin
      data = (sel == RS_DRVHD) ? DRVHD_SET : 8'h00;
    end else begin
      case (sel)
        RS_FEAT_ERR: data = err;
        RS_SCNT:     data = scnt;
        RS_SNUM:     data = snum;
        RS_CYLL:     data = cyll;
        RS_CYLH:     data = cylh;
        RS_DRVHD:    data = drvhd;
        RS_CMD_STAT,
        RS_DEVCTL:   data = stat;
        default:     data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3,
  parameter logic [ADDR_W-1:0] CH0_BASE = 16'h01F0,
  parameter logic [ADDR_W-1:0] CH1_BASE = 16'h0170,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 16'h0206
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    port_addr,
  input  logic [LEN_W-1:0]     acc_bytes,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [3:0]           drv_present,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic                 acc_err,
  output logic                 cmd_valid,
  output logic                 cmd_chan,
  output logic [DATA_W-1:0]    cmd_code,
  output logic [1:0]           drv_sel,
  output logic [1:0]           lba_mode,
  output logic [2*DATA_W-1:0]  feat_q,
  output logic [2*DATA_W-1:0]  devctl_q
);
  localparam int NCH = 2;

  logic     hit, chan;
  tf_sel_e  sel;
  tf_regs_t regs [NCH];
  logic     legal, rd_ok, wr_ok, bad;
  logic [DATA_W-1:0] rd_next;
  logic     present_sel;

  ata_port_decode #(
    .ADDR_W(ADDR_W), .CH0_BASE(CH0_BASE), .CH1_BASE(CH1_BASE), .CTRL_OFS(CTRL_OFS)
  ) u_dec (
    .addr(port_addr), .hit(hit), .chan(chan), .sel(sel)
  );

  assign legal = (acc_bytes == LEN_W'(1));
  assign rd_ok = rd_stb && legal && hit && (sel != RS_DATA);
  assign wr_ok = wr_stb && legal && hit && (sel != RS_DATA) && (sel != RS_ALTADDR);
  assign bad   = (rd_stb && !rd_ok) || (wr_stb && !wr_ok);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ata_chan_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst),
      .wr_en(wr_ok && (chan == 1'(c))),
      .sel(sel), .wr_data(wr_data),
      .q(regs[c])
    );
    assign drv_sel[c]  = regs[c].drvhd[DRVSEL_BIT];
    assign lba_mode[c] = regs[c].drvhd[LBA_BIT];
    assign feat_q[c*DATA_W +: DATA_W]   = regs[c].feat;
    assign devctl_q[c*DATA_W +: DATA_W] = regs[c].devctl;
  end

  assign present_sel = drv_present[{chan, regs[chan].drvhd[DRVSEL_BIT]}];

  ata_read_mux u_rmux (
    .sel(sel), .present(present_sel),
    .err(regs[chan].err), .scnt(regs[chan].scnt), .snum(regs[chan].snum),
    .cyll(regs[chan].cyll), .cylh(regs[chan].cylh), .drvhd(regs[chan].drvhd),
    .stat(regs[chan].stat), .data(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      acc_err   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_chan  <= 1'b0;
    end else begin
      rd_valid  <= rd_ok;
      acc_err   <= bad;
      cmd_valid <= wr_ok && (sel == RS_CMD_STAT);
      if (rd_ok) rd_data <= rd_next;
      if (wr_ok && (sel == RS_CMD_STAT)) cmd_chan <= chan;
    end
  end

  assign cmd_code = regs[cmd_chan].cmd;
endmodule

// File: rtl/ata_taskfile_regs_chk.sv
module ata_taskfile_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] port_addr,
  input logic [2:0]  acc_bytes,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic [3:0]  drv_present,
  input logic [7:0]  rd_data,
  input logic        rd_valid,
  input logic        acc_err,
  input logic        cmd_valid
);
  // R12: read data only follows a read strobe
  a_r12_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_stb));

  // R4: command pulse only after a write to offset 7
  a_r4_cmd_from_write: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_stb && (port_addr[2:0] == 3'd7)));

  // R6: unused address port reads all ones
  a_r6_unused_port_ff: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stb && (acc_bytes == 3'd1) && ((port_addr == 16'h03F7) || (port_addr == 16'h0377)))
      |-> (rd_valid && (rd_data == 8'hFF)));

  // R7: channel 0 with no drives reads 0xA0 from drive/head
  a_r7_absent_drvhd: assert property (@(posedge clk) disable iff (rst)
    $past(rd_stb && (acc_bytes == 3'd1) && (port_addr == 16'h01F6) && (drv_present[1:0] == 2'b00))
      |-> (rd_data == 8'hA0));

  // R8: bad width gives error and nothing else
  a_r8_bad_width: assert property (@(posedge clk) disable iff (rst)
    $past((rd_stb || wr_stb) && (acc_bytes != 3'd1)) |-> (acc_err && !rd_valid && !cmd_valid));

  // R11: data port access is an error
  a_r11_data_port_err: assert property (@(posedge clk) disable iff (rst)
    $past((rd_stb || wr_stb) && ((port_addr == 16'h01F0) || (port_addr == 16'h0170)))
      |-> (acc_err && !rd_valid));
endmodule

bind ata_taskfile_regs ata_taskfile_regs_chk u_chk (.*);

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] port_addr = '0;
  logic [2:0]  acc_bytes = 3'd1;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  drv_present = 4'b1111;
  logic [7:0]  rd_data;
  logic        rd_valid, acc_err, cmd_valid, cmd_chan;
  logic [7:0]  cmd_code;
  logic [1:0]  drv_sel, lba_mode;
  logic [15:0] feat_q, devctl_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  ata_taskfile_regs u_dut (
    .clk(clk), .rst(rst), .port_addr(port_addr), .acc_bytes(acc_bytes),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data), .drv_present(drv_present),
    .rd_data(rd_data), .rd_valid(rd_valid), .acc_err(acc_err), .cmd_valid(cmd_valid),
    .cmd_chan(cmd_chan), .cmd_code(cmd_code), .drv_sel(drv_sel), .lba_mode(lba_mode),
    .feat_q(feat_q), .devctl_q(devctl_q)
  );

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  // monitor: pops expected read bytes as results come out
  always @(posedge clk) begin
    #1;
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected rd_valid", 32'(rd_data), 32'h0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rd_data == e, t, 32'(rd_data), 32'(e));
      end
    end
  end

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    port_addr = a; acc_bytes = 3'd1; rd_stb = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit exp_cmd, input string t);
    @(negedge clk);
    port_addr = a; acc_bytes = 3'd1; wr_data = d; wr_stb = 1'b1;
    @(posedge clk); #1;
    chk(acc_err == 1'b0, {t, " no error"}, 32'(acc_err), 32'h0);
    chk(cmd_valid == exp_cmd, {t, " cmd_valid"}, 32'(cmd_valid), 32'(exp_cmd));
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic bad(input logic [15:0] a, input bit is_wr, input logic [2:0] len, input string t);
    @(negedge clk);
    port_addr = a; acc_bytes = len; wr_data = 8'h99;
    if (is_wr) wr_stb = 1'b1; else rd_stb = 1'b1;
    @(posedge clk); #1;
    chk(acc_err == 1'b1, {t, " acc_err"}, 32'(acc_err), 32'h1);
    chk(!rd_valid && !cmd_valid, {t, " silent"}, 32'({rd_valid, cmd_valid}), 32'h0);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; acc_bytes = 3'd1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk(devctl_q == 16'h0808, "R2 devctl reset", 32'(devctl_q), 32'h0808);
    chk(feat_q == 16'h0000, "R2 features reset", 32'(feat_q), 32'h0);
    chk(drv_sel == 2'b00 && lba_mode == 2'b00, "R2 R9 sel/lba reset", 32'({drv_sel, lba_mode}), 32'h0);
    chk(!rd_valid && !acc_err && !cmd_valid, "R2 pulses low", 32'({rd_valid, acc_err, cmd_valid}), 32'h0);
    rd(16'h01F1, 8'h01, "R2 ch0 error");
    rd(16'h01F2, 8'h01, "R2 ch0 sector count");
    rd(16'h01F3, 8'h01, "R2 ch0 sector number");
    rd(16'h01F4, 8'h00, "R2 ch0 cyl low");
    rd(16'h01F5, 8'h00, "R2 ch0 cyl high");
    rd(16'h01F6, 8'h00, "R2 ch0 drive/head");
    rd(16'h01F7, 8'h00, "R2 ch0 status");
    rd(16'h0172, 8'h01, "R2 ch1 sector count");
    rd(16'h0176, 8'h00, "R2 ch1 drive/head");

    // R1 channel routing and independence
    wr(16'h01F2, 8'h5A, 1'b0, "R1 wr ch0 scnt");
    wr(16'h0172, 8'hC3, 1'b0, "R1 wr ch1 scnt");
    wr(16'h01F4, 8'h11, 1'b0, "R1 wr ch0 cyll");
    wr(16'h0175, 8'h22, 1'b0, "R1 wr ch1 cylh");
    wr(16'h01F3, 8'h33, 1'b0, "R1 wr ch0 snum");
    rd(16'h01F2, 8'h5A, "R1 ch0 scnt");
    rd(16'h0172, 8'hC3, "R1 ch1 scnt");
    rd(16'h0174, 8'h00, "R1 ch1 cyll untouched");
    rd(16'h01F4, 8'h11, "R1 ch0 cyll");
    rd(16'h0175, 8'h22, "R1 ch1 cylh");
    rd(16'h01F5, 8'h00, "R1 ch0 cylh untouched");
    rd(16'h01F3, 8'h33, "R1 ch0 snum");

    // R3 features/error split
    wr(16'h01F1, 8'h77, 1'b0, "R3 wr features");
    rd(16'h01F1, 8'h01, "R3 read gives error");
    chk(feat_q == 16'h0077, "R3 features captured", 32'(feat_q), 32'h0077);

    // R4 command/status split and pulse
    wr(16'h0177, 8'hEC, 1'b1, "R4 wr command ch1");
    chk(cmd_chan == 1'b1, "R4 cmd_chan", 32'(cmd_chan), 32'h1);
    chk(cmd_code == 8'hEC, "R4 cmd_code", 32'(cmd_code), 32'hEC);
    @(posedge clk); #1;
    chk(cmd_valid == 1'b0, "R4 single-cycle pulse", 32'(cmd_valid), 32'h0);
    wr(16'h01F7, 8'h20, 1'b1, "R4 wr command ch0");
    chk(cmd_chan == 1'b0 && cmd_code == 8'h20, "R4 ch0 cmd", 32'({cmd_chan, cmd_code}), 32'h020);
    rd(16'h0177, 8'h00, "R4 read gives status");
    rd(16'h0376, 8'h00, "R4 control port reads status");

    // R5 / R9 drive/head forced bits and outputs
    wr(16'h01F6, 8'h00, 1'b0, "R5 wr ch0 drvhd");
    rd(16'h01F6, 8'hA0, "R5 reserved bits forced");
    wr(16'h0176, 8'h50, 1'b0, "R5 wr ch1 drvhd");
    rd(16'h0176, 8'hF0, "R5 ch1 drvhd");
    chk(drv_sel == 2'b10 && lba_mode == 2'b10, "R9 sel/lba outputs", 32'({drv_sel, lba_mode}), 32'hA);

    // R7 / R6 absent drive on channel 1 drive 1
    drv_present = 4'b0111;
    rd(16'h0172, 8'h00, "R7 absent scnt");
    rd(16'h0176, 8'hA0, "R7 absent drvhd");
    rd(16'h0177, 8'h00, "R7 absent status");
    rd(16'h0377, 8'hFF, "R6 unused port absent drive");
    rd(16'h03F7, 8'hFF, "R6 unused port ch0");
    rd(16'h01F2, 8'h5A, "R7 ch0 unaffected");
    wr(16'h0174, 8'h44, 1'b0, "R7 write while absent");
    wr(16'h0176, 8'h00, 1'b0, "R7 select drive 0");
    rd(16'h0172, 8'hC3, "R7 stored value kept");
    rd(16'h0174, 8'h44, "R7 write took effect");
    drv_present = 4'b1111;

    // R8 bad widths
    bad(16'h01F3, 1'b1, 3'd2, "R8 wide write");
    rd(16'h01F3, 8'h33, "R8 register unchanged");
    bad(16'h01F2, 1'b0, 3'd4, "R8 wide read");
    bad(16'h01F7, 1'b1, 3'd0, "R8 zero-width command");

    // R11 undecoded and data ports
    bad(16'h01F0, 1'b0, 3'd1, "R11 read data port");
    bad(16'h0170, 1'b1, 3'd1, "R11 write data port");
    bad(16'h01F8, 1'b0, 3'd1, "R11 undecoded read");
    bad(16'h03F5, 1'b1, 3'd1, "R11 undecoded write");
    bad(16'h03F7, 1'b1, 3'd1, "R11 write unused port");
    rd(16'h01F2, 8'h5A, "R11 no side effect");

    // R10 soft reset on channel 0
    wr(16'h03F6, 8'h0E, 1'b0, "R10 control write");
    idle(2);
    chk(devctl_q == 16'h080E, "R10 control kept", 32'(devctl_q), 32'h080E);
    chk(feat_q == 16'h0000, "R10 features cleared", 32'(feat_q), 32'h0);
    rd(16'h01F2, 8'h01, "R10 scnt restored");
    rd(16'h01F3, 8'h01, "R10 snum restored");
    rd(16'h01F4, 8'h00, "R10 cyll restored");
    rd(16'h01F6, 8'h00, "R10 drvhd restored");
    rd(16'h0172, 8'hC3, "R10 ch1 untouched");
    rd(16'h0175, 8'h22, "R10 ch1 cylh untouched");
    wr(16'h03F6, 8'h02, 1'b0, "R10 control without reset bit");
    wr(16'h01F2, 8'h66, 1'b0, "R10 wr scnt");
    idle(2);
    rd(16'h01F2, 8'h66, "R10 no clear without bit");

    idle(3);
    chk(exp_q.size() == 0, "R12 every read answered", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule